// File: doc/BRIEF.md
# Operand-Waiting Issue Queue with Result Snooping

This block sits in front of a single execution unit. It keeps a few slots of issued instructions until their operands are known. Each slot holds an operation code, the instruction's own tag and two source operands. Every operand carries a value, a ready flag and, while it is not ready, the tag of the older instruction that will produce it. Every slot watches the shared result broadcast bus all the time. When a pending operand's producer tag appears on a valid broadcast, the slot copies the value into that operand and marks it ready.

A slot is eligible once both of its operands are ready. When the execution unit reports that it can take work, the eligible instruction that entered the queue earliest leaves the queue. It appears on registered dispatch outputs one cycle later. The issue stage must hold its instruction while the full flag is high. An issue attempted while the queue is full is dropped.

Top module: `resv_station`

## Requirements
- R1: After a synchronous reset, all slots are empty, `full` is 0 and `disp_valid` is 0.
- R2: When `issue_valid` is 1 and `full` is 0, the instruction is written into a free slot at the clock edge. `full` is 1 exactly when all NUM_SLOTS slots are occupied. An issue presented while `full` is 1 is dropped and never dispatched.
- R3: An operand issued with its ready bit at 1 keeps its issued value up to dispatch, even when a broadcast carries a tag equal to that operand's tag field.
- R4: A pending operand takes `cdb_data` and becomes ready at an edge where `cdb_valid` is 1 and `cdb_tag` equals its producer tag. It does not change when the tag differs or when `cdb_valid` is 0.
- R5: An issued operand whose producer tag matches a valid broadcast in the same cycle captures that broadcast value at entry.
- R6: A slot is dispatched only at an edge where both of its operands are already ready and `fu_ready` is 1. A slot whose last operand is captured at edge E can fire at edge E+1 at the earliest. `disp_valid` is 1 for the cycle that follows the firing edge.
- R7: When several slots are eligible, the one issued earliest is dispatched first. This order does not depend on slot position.
- R8: A slot freed by dispatch accepts a new issue from the cycle after the dispatch. `full` drops in that cycle.
- R9: The dispatch outputs carry the slot's operation code, its tag and the final values of both operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_valid | input | 1 | Issue request |
| issue_op | input | OP_W | Operation code of the issued instruction |
| issue_tag | input | TAG_W | Tag of the issued instruction |
| issue_a_rdy | input | 1 | Operand A value is known |
| issue_a_tag | input | TAG_W | Producer tag of operand A |
| issue_a_val | input | DATA_W | Value of operand A |
| issue_b_rdy | input | 1 | Operand B value is known |
| issue_b_tag | input | TAG_W | Producer tag of operand B |
| issue_b_val | input | DATA_W | Value of operand B |
| full | output | 1 | All slots occupied; issue must stall |
| cdb_valid | input | 1 | Result broadcast is valid |
| cdb_tag | input | TAG_W | Tag of the broadcast result |
| cdb_data | input | DATA_W | Broadcast result value |
| fu_ready | input | 1 | Execution unit can accept an instruction |
| disp_valid | output | 1 | Dispatched instruction valid |
| disp_op | output | OP_W | Dispatched operation code |
| disp_tag | output | TAG_W | Dispatched instruction tag |
| disp_a | output | DATA_W | Dispatched operand A value |
| disp_b | output | DATA_W | Dispatched operand B value |

## Verification
Several properties are checked on every cycle. A matching broadcast is captured into a pending operand, and a ready operand stays stable. At most one slot is granted. The age relation between any two occupied slots stays consistent. A dispatch always follows a cycle with `fu_ready` high, and `full` holds or drops correctly around a dispatch. Other behaviour shows only in the bench's scenarios: the actual oldest-first order after a slot is reused out of position, the dropping of an issue made while full, capture at entry, and the operand values at the dispatch outputs.

// File: rtl/rs_pkg.sv
package rs_pkg;
  localparam int DATA_W = 32;
  localparam int TAG_W  = 5;
  localparam int OP_W   = 6;

  typedef struct packed {
    logic              rdy;
    logic [TAG_W-1:0]  tag;
    logic [DATA_W-1:0] val;
  } opnd_t;

  typedef struct packed {
    logic [OP_W-1:0]  op;
    logic [TAG_W-1:0] tag;
    opnd_t            a;
    opnd_t            b;
  } instr_t;

  // Returns the operand after watching one broadcast.
  function automatic opnd_t snoop(input opnd_t o, input logic cv,
                                  input logic [TAG_W-1:0] ct,
                                  input logic [DATA_W-1:0] cd);
    opnd_t r;
    r = o;
    if (!o.rdy && cv && (o.tag == ct)) begin
      r.rdy = 1'b1;
      r.val = cd;
    end
    return r;
  endfunction
endpackage

// File: rtl/rs_entry.sv
module rs_entry
  import rs_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              clr,
  input  instr_t            wr_instr,
  input  logic              cdb_valid,
  input  logic [TAG_W-1:0]  cdb_tag,
  input  logic [DATA_W-1:0] cdb_data,
  output logic              busy,
  output instr_t            slot,
  output logic              ready
);
  always_ff @(posedge clk) begin
    if (rst)        busy <= 1'b0;
    else if (wr_en) busy <= 1'b1;
    else if (clr)   busy <= 1'b0;
  end

  // Payload has no reset so it maps onto plain registers.
  always_ff @(posedge clk) begin
    if (wr_en) begin
      slot.op  <= wr_instr.op;
      slot.tag <= wr_instr.tag;
      slot.a   <= snoop(wr_instr.a, cdb_valid, cdb_tag, cdb_data);
      slot.b   <= snoop(wr_instr.b, cdb_valid, cdb_tag, cdb_data);
    end else begin
      slot.a   <= snoop(slot.a, cdb_valid, cdb_tag, cdb_data);
      slot.b   <= snoop(slot.b, cdb_valid, cdb_tag, cdb_data);
    end
  end

  assign ready = busy && slot.a.rdy && slot.b.rdy;

  AST_CAPTURE_A: assert property (@(posedge clk) disable iff (rst)
    (busy && !wr_en && !slot.a.rdy && cdb_valid && cdb_tag == slot.a.tag)
    |=> (slot.a.rdy && slot.a.val == $past(cdb_data))); // R4
  AST_CAPTURE_B: assert property (@(posedge clk) disable iff (rst)
    (busy && !wr_en && !slot.b.rdy && cdb_valid && cdb_tag == slot.b.tag)
    |=> (slot.b.rdy && slot.b.val == $past(cdb_data))); // R4
  AST_KEEP_READY_A: assert property (@(posedge clk) disable iff (rst)
    (busy && !wr_en && slot.a.rdy) |=> (slot.a.rdy && $stable(slot.a.val))); // R3
  AST_KEEP_READY_B: assert property (@(posedge clk) disable iff (rst)
    (busy && !wr_en && slot.b.rdy) |=> (slot.b.rdy && $stable(slot.b.val))); // R3
endmodule

// File: rtl/rs_free_pick.sv
module rs_free_pick #(
  parameter int N = 4
) (
  input  logic [N-1:0] busy,
  output logic         any_free,
  output logic [N-1:0] pick
);
  always_comb begin
    pick = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!busy[i]) begin
        pick    = '0;
        pick[i] = 1'b1;
      end
    end
  end

  assign any_free = ~&busy;
endmodule

// File: rtl/rs_age_select.sv
module rs_age_select #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] alloc,
  input  logic [N-1:0] busy,
  input  logic [N-1:0] ready,
  output logic [N-1:0] grant
);
  // older[i][j] set: slot i was issued before slot j.
  logic [N-1:0] older [N];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) older[i] <= '0;
    end else begin
      for (int i = 0; i < N; i++) begin
        for (int j = 0; j < N; j++) begin
          if (alloc[i])      older[i][j] <= 1'b0;
          else if (alloc[j]) older[i][j] <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    for (int i = 0; i < N; i++) begin
      logic blk;
      blk = 1'b0;
      for (int j = 0; j < N; j++) begin
        if (j != i && ready[j] && older[j][i]) blk = 1'b1;
      end
      grant[i] = ready[i] && !blk;
    end
  end

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant)); // R7

  for (genvar gi = 0; gi < N; gi++) begin : g_row
    for (genvar gj = gi + 1; gj < N; gj++) begin : g_col
      AST_AGE_ORDER: assert property (@(posedge clk) disable iff (rst)
        (busy[gi] && busy[gj]) |-> (older[gi][gj] != older[gj][gi])); // R7
    end
  end
endmodule

// File: rtl/resv_station.sv
module resv_station
  import rs_pkg::*;
#(
  parameter int NUM_SLOTS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              issue_valid,
  input  logic [OP_W-1:0]   issue_op,
  input  logic [TAG_W-1:0]  issue_tag,
  input  logic              issue_a_rdy,
  input  logic [TAG_W-1:0]  issue_a_tag,
  input  logic [DATA_W-1:0] issue_a_val,
  input  logic              issue_b_rdy,
  input  logic [TAG_W-1:0]  issue_b_tag,
  input  logic [DATA_W-1:0] issue_b_val,
  output logic              full,
  input  logic              cdb_valid,
  input  logic [TAG_W-1:0]  cdb_tag,
  input  logic [DATA_W-1:0] cdb_data,
  input  logic              fu_ready,
  output logic              disp_valid,
  output logic [OP_W-1:0]   disp_op,
  output logic [TAG_W-1:0]  disp_tag,
  output logic [DATA_W-1:0] disp_a,
  output logic [DATA_W-1:0] disp_b
);
  logic [NUM_SLOTS-1:0] busy, ready, pick, grant, wr_en, clr;
  logic                 any_free, accept, fire;
  instr_t               slots [NUM_SLOTS];
  instr_t               new_instr, sel;

  assign new_instr.op  = issue_op;
  assign new_instr.tag = issue_tag;
  assign new_instr.a   = '{rdy: issue_a_rdy, tag: issue_a_tag, val: issue_a_val};
  assign new_instr.b   = '{rdy: issue_b_rdy, tag: issue_b_tag, val: issue_b_val};

  assign full   = !any_free;
  assign accept = issue_valid && any_free;
  assign fire   = fu_ready && (|ready);
  assign wr_en  = pick & {NUM_SLOTS{accept}};
  assign clr    = grant & {NUM_SLOTS{fire}};

  rs_free_pick #(.N(NUM_SLOTS)) i_free_pick (
    .busy(busy), .any_free(any_free), .pick(pick)
  );

  rs_age_select #(.N(NUM_SLOTS)) i_age_select (
    .clk(clk), .rst(rst), .alloc(wr_en), .busy(busy),
    .ready(ready), .grant(grant)
  );

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    rs_entry i_entry (
      .clk(clk), .rst(rst), .wr_en(wr_en[s]), .clr(clr[s]),
      .wr_instr(new_instr), .cdb_valid(cdb_valid), .cdb_tag(cdb_tag),
      .cdb_data(cdb_data), .busy(busy[s]), .slot(slots[s]),
      .ready(ready[s])
    );
  end

  always_comb begin
    sel = '0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (grant[i]) sel = sel | slots[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      disp_valid <= 1'b0;
      disp_op    <= '0;
      disp_tag   <= '0;
      disp_a     <= '0;
      disp_b     <= '0;
    end else begin
      disp_valid <= fire;
      if (fire) begin
        disp_op  <= sel.op;
        disp_tag <= sel.tag;
        disp_a   <= sel.a.val;
        disp_b   <= sel.b.val;
      end
    end
  end

  AST_DISP_NEEDS_FU: assert property (@(posedge clk) disable iff (rst)
    disp_valid |-> $past(fu_ready)); // R6
  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (full && !fire) |=> full); // R2
  AST_FREE_AFTER_DISP: assert property (@(posedge clk) disable iff (rst)
    (full && fire) |=> !full); // R8
endmodule

// File: tb/test_resv_station.sv
module test_resv_station;
  import rs_pkg::*;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              issue_valid = 1'b0;
  logic [OP_W-1:0]   issue_op = '0;
  logic [TAG_W-1:0]  issue_tag = '0;
  logic              issue_a_rdy = 1'b0;
  logic [TAG_W-1:0]  issue_a_tag = '0;
  logic [DATA_W-1:0] issue_a_val = '0;
  logic              issue_b_rdy = 1'b0;
  logic [TAG_W-1:0]  issue_b_tag = '0;
  logic [DATA_W-1:0] issue_b_val = '0;
  logic              full;
  logic              cdb_valid = 1'b0;
  logic [TAG_W-1:0]  cdb_tag = '0;
  logic [DATA_W-1:0] cdb_data = '0;
  logic              fu_ready = 1'b0;
  logic              disp_valid;
  logic [OP_W-1:0]   disp_op;
  logic [TAG_W-1:0]  disp_tag;
  logic [DATA_W-1:0] disp_a, disp_b;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  resv_station #(.NUM_SLOTS(4)) i_resv_station (
    .clk(clk), .rst(rst), .issue_valid(issue_valid), .issue_op(issue_op),
    .issue_tag(issue_tag), .issue_a_rdy(issue_a_rdy), .issue_a_tag(issue_a_tag),
    .issue_a_val(issue_a_val), .issue_b_rdy(issue_b_rdy),
    .issue_b_tag(issue_b_tag), .issue_b_val(issue_b_val), .full(full),
    .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_data(cdb_data),
    .fu_ready(fu_ready), .disp_valid(disp_valid), .disp_op(disp_op),
    .disp_tag(disp_tag), .disp_a(disp_a), .disp_b(disp_b)
  );

  typedef struct packed {
    logic        a_rdy;
    logic [4:0]  a_tag;
    logic [31:0] a_val;
    logic        b_rdy;
    logic [4:0]  b_tag;
    logic [31:0] b_val;
    logic        same;
    logic [4:0]  bc_tag;
    logic [31:0] bc_data;
    logic [31:0] exp_a;
    logic [31:0] exp_b;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 5'd0,  32'h11, 1'b1, 5'd0,  32'h22, 1'b0, 5'd30, 32'hDEAD, 32'h11,  32'h22},
    '{1'b0, 5'd3,  32'h0,  1'b1, 5'd0,  32'h44, 1'b0, 5'd3,  32'hA3,   32'hA3,  32'h44},
    '{1'b1, 5'd0,  32'h5,  1'b0, 5'd7,  32'h0,  1'b0, 5'd7,  32'hB7,   32'h5,   32'hB7},
    '{1'b0, 5'd9,  32'h0,  1'b0, 5'd9,  32'h0,  1'b0, 5'd9,  32'h99,   32'h99,  32'h99},
    '{1'b0, 5'd12, 32'h0,  1'b1, 5'd0,  32'h66, 1'b1, 5'd12, 32'hC12,  32'hC12, 32'h66},
    '{1'b1, 5'd14, 32'h77, 1'b0, 5'd14, 32'h0,  1'b0, 5'd14, 32'hE14,  32'h77,  32'hE14}
  };

  task automatic chk(input bit ok, input string req,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic set_issue(input logic [5:0] op, input logic [4:0] tg,
                           input logic ar, input logic [4:0] at, input logic [31:0] av,
                           input logic br, input logic [4:0] bt, input logic [31:0] bv);
    issue_valid = 1'b1; issue_op = op; issue_tag = tg;
    issue_a_rdy = ar; issue_a_tag = at; issue_a_val = av;
    issue_b_rdy = br; issue_b_tag = bt; issue_b_val = bv;
  endtask

  task automatic bcast(input logic v, input logic [4:0] tg, input logic [31:0] d);
    cdb_valid = v; cdb_tag = tg; cdb_data = d;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [4:0] exp_order [4];
    int n;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(full == 1'b0, "R1 full", full, 0);
    chk(disp_valid == 1'b0, "R1 disp_valid", disp_valid, 0);

    // Vector table: one instruction each, operands resolved by broadcast
    for (int k = 0; k < NV; k++) begin
      fu_ready = 1'b0;
      set_issue(6'(k), 5'(16 + k), VECS[k].a_rdy, VECS[k].a_tag, VECS[k].a_val,
                VECS[k].b_rdy, VECS[k].b_tag, VECS[k].b_val);
      if (VECS[k].same) bcast(1'b1, VECS[k].bc_tag, VECS[k].bc_data); // R5
      @(negedge clk);
      issue_valid = 1'b0;
      if (!VECS[k].same) bcast(1'b1, VECS[k].bc_tag, VECS[k].bc_data);
      else bcast(1'b0, 5'd0, 32'h0);
      @(negedge clk);
      bcast(1'b0, 5'd0, 32'h0);
      chk(disp_valid == 1'b0, "R6 no dispatch while unit busy", disp_valid, 0);
      fu_ready = 1'b1;
      for (int c = 0; c < 6 && !disp_valid; c++) @(negedge clk);
      fu_ready = 1'b0;
      chk(disp_valid == 1'b1, "R6 dispatch occurs", disp_valid, 1);
      chk(disp_tag == 5'(16 + k) && disp_op == 6'(k), "R9 tag/op", disp_tag, 16 + k);
      chk(disp_a == VECS[k].exp_a, "R3 R4 R5 operand A", disp_a, VECS[k].exp_a);
      chk(disp_b == VECS[k].exp_b, "R3 R4 R5 operand B", disp_b, VECS[k].exp_b);
      @(negedge clk);
    end

    // R2 R7 R8: fill, drop an issue while full, then oldest-first drain
    fu_ready = 1'b0;
    set_issue(6'd1, 5'd1, 1'b0, 5'd9,  32'h0, 1'b1, 5'd0, 32'h100); @(negedge clk);
    set_issue(6'd2, 5'd2, 1'b1, 5'd0, 32'h2, 1'b1, 5'd0, 32'h200); @(negedge clk);
    set_issue(6'd3, 5'd3, 1'b0, 5'd10, 32'h0, 1'b1, 5'd0, 32'h300); @(negedge clk);
    set_issue(6'd4, 5'd4, 1'b1, 5'd0, 32'h4, 1'b1, 5'd0, 32'h400); @(negedge clk);
    chk(full == 1'b1, "R2 full after four issues", full, 1);
    set_issue(6'd5, 5'd5, 1'b1, 5'd0, 32'h5, 1'b1, 5'd0, 32'h500); @(negedge clk);
    issue_valid = 1'b0;
    bcast(1'b1, 5'd10, 32'hAAA); @(negedge clk);
    bcast(1'b1, 5'd9, 32'h999);  @(negedge clk);
    bcast(1'b0, 5'd0, 32'h0);
    chk(full == 1'b1, "R2 still full without dispatch", full, 1);
    fu_ready = 1'b1;
    @(negedge clk);
    fu_ready = 1'b0;
    chk(disp_valid == 1'b1 && disp_tag == 5'd1, "R7 oldest first", disp_tag, 1);
    chk(disp_a == 32'h999, "R4 captured value", disp_a, 32'h999);
    chk(full == 1'b0, "R8 slot free after dispatch", full, 0);
    set_issue(6'd6, 5'd6, 1'b1, 5'd0, 32'h6, 1'b1, 5'd0, 32'h600); @(negedge clk);
    issue_valid = 1'b0;
    chk(full == 1'b1, "R8 freed slot reused", full, 1);
    exp_order = '{5'd2, 5'd3, 5'd4, 5'd6};
    n = 0;
    fu_ready = 1'b1;
    for (int c = 0; c < 12; c++) begin
      @(negedge clk);
      if (disp_valid) begin
        if (n < 4) chk(disp_tag == exp_order[n], "R7 age order", disp_tag, exp_order[n]);
        chk(disp_tag != 5'd5, "R2 dropped issue dispatched", disp_tag, 0);
        n++;
      end
    end
    fu_ready = 1'b0;
    chk(n == 4, "R2 dispatch count", n, 4);

    // R4 no capture on tag mismatch or invalid broadcast; R6 exact timing
    @(negedge clk);
    set_issue(6'd7, 5'd7, 1'b0, 5'd5, 32'h0, 1'b1, 5'd0, 32'h777); @(negedge clk);
    issue_valid = 1'b0;
    bcast(1'b1, 5'd6, 32'hBAD); @(negedge clk);
    bcast(1'b0, 5'd5, 32'hBAD); @(negedge clk);
    bcast(1'b0, 5'd0, 32'h0);
    fu_ready = 1'b1;
    n = 0;
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      if (disp_valid) n++;
    end
    chk(n == 0, "R4 no capture on mismatch or invalid bus", n, 0);
    bcast(1'b1, 5'd5, 32'h55); @(negedge clk);
    bcast(1'b0, 5'd0, 32'h0);
    chk(disp_valid == 1'b0, "R6 not dispatched in capture cycle", disp_valid, 0);
    @(negedge clk);
    chk(disp_valid == 1'b1 && disp_tag == 5'd7, "R6 dispatch next edge", disp_tag, 7);
    chk(disp_a == 32'h55 && disp_b == 32'h777, "R9 operand values", disp_a, 32'h55);
    fu_ready = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule